// File: doc/BRIEF.md
# Knock Front-End SPI Command Decoder

This block is the device side of the serial port of a knock-signal conditioning front end. A host writes one-byte commands over SPI. A prefix code in the upper bits of each byte selects one of five settings: clock prescaler, input channel, band-pass centre index, gain index or integrator time-constant index. The block holds these settings in registers and drives them out to the analog section. The filter, integrator and converter are outside this block.

A special unlock byte switches the block into advanced mode. In that mode, each recognised command is answered on MISO during the next transfer with a fixed acknowledge byte. The host can use this reply to confirm that the command arrived. Outside advanced mode, MISO always returns zero.

The SPI pins are oversampled by the block clock through synchronisers. SCLK therefore has to be much slower than the block clock.

Top module: `knk_cmd_front`

## Requirements
- R1: While rst_ni is low and after it is released, with no transfer since, every setting output is 0, adv_o is 0 and miso_o is 0.
- R2: A complete byte of the form 00bbbbbb sets band_o to bbbbbb.
- R3: A complete byte of the form 10gggggg sets gain_o to gggggg.
- R4: A complete byte of the form 110iiiii sets integ_o to iiiii.
- R5: A complete byte of the form 010ppppp sets presc_o to ppppp. clk_mhz_o reports the input clock chosen by presc_o[4:1]: codes 0..8 map to 4, 5, 6, 8, 10, 12, 16, 20 and 24. Codes 9..15 give 0.
- R6: A complete byte 1110000c sets chan_o to c.
- R7: Byte 0x71 sets adv_o, which then stays set until reset. The transfer that follows returns 0x8E on MISO.
- R8: With adv_o set, the transfer after a command returns the following on MISO: 0x01 after a band byte, 0xE0 after a gain byte, 0x71 after an integrator byte, and 0x00 after a prescaler, channel or unmatched byte.
- R9: While adv_o is clear, every transfer returns 0x00 on MISO.
- R10: Any other byte changes no setting and does not change adv_o. This covers 011xxxxx other than 0x71, 1111xxxx and 11100010..11101111.
- R11: Transfers are SPI mode 0, MSB first. MOSI is taken on rising SCLK. MISO changes only on falling SCLK or at the start of a frame, and it is 0 while CS_n is high.
- R12: A frame that ends before the eighth rising SCLK edge is discarded. No setting changes, and the pending acknowledge is still returned by the next complete transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, oversamples the SPI pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | SPI serial clock, idle low |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | SPI data from host |
| miso_o | output | 1 | SPI data to host |
| presc_o | output | 5 | Prescaler field |
| clk_mhz_o | output | 5 | Input clock in MHz decoded from presc_o[4:1], 0 if unlisted |
| chan_o | output | 1 | Selected input channel |
| band_o | output | 6 | Band-pass centre index |
| gain_o | output | 6 | Gain index |
| integ_o | output | 5 | Integrator time-constant index |
| adv_o | output | 1 | Advanced mode active |

## Verification
The hardest case to reach from the ports is a pending acknowledge that must survive an aborted frame. To produce it, a band command is issued in advanced mode. Then chip select is dropped after only four clocks. The next full transfer must still return 0x01, and none of the settings may have moved. The bench also walks through the unlock sequence from cold. This shows that the unlock transfer itself returns zero and that the 0x8E reply appears only one transfer later. Every reply is compared through a queue of expected items.

// File: rtl/knk_pkg.sv
package knk_pkg;
  localparam int CMD_W   = 8;
  localparam int BAND_W  = 6;
  localparam int GAIN_W  = 6;
  localparam int INTEG_W = 5;
  localparam int PRESC_W = 5;
  localparam int MHZ_W   = 5;
  localparam int CNT_W   = $clog2(CMD_W);

  localparam logic [CMD_W-1:0] UNLOCK_BYTE = 8'h71;
  localparam logic [CMD_W-1:0] ACK_BAND    = 8'h01;
  localparam logic [CMD_W-1:0] ACK_GAIN    = 8'hE0;
  localparam logic [CMD_W-1:0] ACK_INTEG   = 8'h71;
  localparam logic [CMD_W-1:0] ACK_UNLOCK  = ~UNLOCK_BYTE;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_BAND, CMD_GAIN, CMD_INTEG, CMD_PRESC, CMD_CHAN, CMD_UNLOCK
  } cmd_kind_e;

  function automatic cmd_kind_e classify(input logic [CMD_W-1:0] b);
    cmd_kind_e k;
    casez (b)
      8'b0111_0001: k = CMD_UNLOCK;
      8'b00??_????: k = CMD_BAND;
      8'b10??_????: k = CMD_GAIN;
      8'b110?_????: k = CMD_INTEG;
      8'b010?_????: k = CMD_PRESC;
      8'b1110_000?: k = CMD_CHAN;
      default:      k = CMD_NONE;
    endcase
    return k;
  endfunction

  function automatic logic [CMD_W-1:0] ack_of(input cmd_kind_e k);
    logic [CMD_W-1:0] a;
    case (k)
      CMD_BAND:   a = ACK_BAND;
      CMD_GAIN:   a = ACK_GAIN;
      CMD_INTEG:  a = ACK_INTEG;
      CMD_UNLOCK: a = ACK_UNLOCK;
      default:    a = '0;
    endcase
    return a;
  endfunction

  function automatic logic [MHZ_W-1:0] clk_mhz(input logic [3:0] sel);
    logic [MHZ_W-1:0] m;
    case (sel)
      4'd0: m = 5'd4;
      4'd1: m = 5'd5;
      4'd2: m = 5'd6;
      4'd3: m = 5'd8;
      4'd4: m = 5'd10;
      4'd5: m = 5'd12;
      4'd6: m = 5'd16;
      4'd7: m = 5'd20;
      4'd8: m = 5'd24;
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/knk_spi_sync.sv
module knk_spi_sync #(
  parameter int             STAGES  = 2,
  parameter int             W       = 3,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] out_o
);
  for (genvar g = 0; g < W; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[g]}};
      else         chain_q <= {chain_q[STAGES-2:0], in_i[g]};
    end
    assign out_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/knk_spi_shift.sv
module knk_spi_shift
  import knk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_s_i,
  input  logic             cs_n_s_i,
  input  logic             mosi_s_i,
  input  logic [CMD_W-1:0] tx_byte_i,
  output logic             byte_done_o,
  output logic [CMD_W-1:0] rx_byte_o,
  output logic             miso_o
);
  logic             sclk_prev_q, cs_prev_q;
  logic             sclk_rise, sclk_fall, cs_act, cs_start;
  logic [CNT_W-1:0] bit_cnt_q;
  logic [CMD_W-1:0] rx_sh_q, tx_sh_q;

  assign sclk_rise = sclk_s_i & ~sclk_prev_q;
  assign sclk_fall = ~sclk_s_i & sclk_prev_q;
  assign cs_act    = ~cs_n_s_i;
  assign cs_start  = ~cs_n_s_i & cs_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q <= 1'b0;
      cs_prev_q   <= 1'b1;
    end else begin
      sclk_prev_q <= sclk_s_i;
      cs_prev_q   <= cs_n_s_i;
    end
  end

  // receive: count rising edges, a partial frame is dropped when CS rises
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q   <= '0;
      rx_sh_q     <= '0;
      rx_byte_o   <= '0;
      byte_done_o <= 1'b0;
    end else begin
      byte_done_o <= 1'b0;
      if (!cs_act) begin
        bit_cnt_q <= '0;
      end else if (sclk_rise) begin
        rx_sh_q   <= {rx_sh_q[CMD_W-2:0], mosi_s_i};
        bit_cnt_q <= bit_cnt_q + CNT_W'(1);
        if (bit_cnt_q == CNT_W'(CMD_W - 1)) begin
          rx_byte_o   <= {rx_sh_q[CMD_W-2:0], mosi_s_i};
          byte_done_o <= 1'b1;
        end
      end
    end
  end

  // transmit: load at frame start or byte boundary, shift on falling SCLK
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh_q <= '0;
    end else if (cs_start) begin
      tx_sh_q <= tx_byte_i;
    end else if (cs_act && sclk_fall) begin
      if (bit_cnt_q == '0) tx_sh_q <= tx_byte_i;
      else                 tx_sh_q <= {tx_sh_q[CMD_W-2:0], 1'b0};
    end
  end

  assign miso_o = cs_act & tx_sh_q[CMD_W-1];
endmodule

// File: rtl/knk_cmd_decode.sv
module knk_cmd_decode
  import knk_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               byte_done_i,
  input  logic [CMD_W-1:0]   byte_i,
  output logic [PRESC_W-1:0] presc_o,
  output logic [MHZ_W-1:0]   clk_mhz_o,
  output logic               chan_o,
  output logic [BAND_W-1:0]  band_o,
  output logic [GAIN_W-1:0]  gain_o,
  output logic [INTEG_W-1:0] integ_o,
  output logic               adv_o,
  output logic [CMD_W-1:0]   ack_o
);
  cmd_kind_e kind;
  logic      adv_next;

  assign kind     = classify(byte_i);
  assign adv_next = adv_o | (kind == CMD_UNLOCK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_o <= '0;
      chan_o  <= 1'b0;
      band_o  <= '0;
      gain_o  <= '0;
      integ_o <= '0;
      adv_o   <= 1'b0;
      ack_o   <= '0;
    end else if (byte_done_i) begin
      case (kind)
        CMD_BAND:  band_o  <= byte_i[BAND_W-1:0];
        CMD_GAIN:  gain_o  <= byte_i[GAIN_W-1:0];
        CMD_INTEG: integ_o <= byte_i[INTEG_W-1:0];
        CMD_PRESC: presc_o <= byte_i[PRESC_W-1:0];
        CMD_CHAN:  chan_o  <= byte_i[0];
        default: ;
      endcase
      adv_o <= adv_next;
      ack_o <= adv_next ? ack_of(kind) : '0;
    end
  end

  assign clk_mhz_o = clk_mhz(presc_o[PRESC_W-1:1]);
endmodule

// File: rtl/knk_cmd_front.sv
module knk_cmd_front
  import knk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               cs_ni,
  input  logic               mosi_i,
  output logic               miso_o,
  output logic [PRESC_W-1:0] presc_o,
  output logic [MHZ_W-1:0]   clk_mhz_o,
  output logic               chan_o,
  output logic [BAND_W-1:0]  band_o,
  output logic [GAIN_W-1:0]  gain_o,
  output logic [INTEG_W-1:0] integ_o,
  output logic               adv_o
);
  logic [2:0]       pin_s;
  logic             byte_done;
  logic [CMD_W-1:0] rx_byte;
  logic [CMD_W-1:0] ack;

  // pin order {mosi, cs_n, sclk}
  knk_spi_sync #(
    .STAGES (SYNC_STAGES),
    .W      (3),
    .RST_VAL(3'b010)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_i  ({mosi_i, cs_ni, sclk_i}),
    .out_o (pin_s)
  );

  knk_spi_shift i_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_s_i   (pin_s[0]),
    .cs_n_s_i   (pin_s[1]),
    .mosi_s_i   (pin_s[2]),
    .tx_byte_i  (ack),
    .byte_done_o(byte_done),
    .rx_byte_o  (rx_byte),
    .miso_o     (miso_o)
  );

  knk_cmd_decode i_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .byte_done_i(byte_done),
    .byte_i     (rx_byte),
    .presc_o    (presc_o),
    .clk_mhz_o  (clk_mhz_o),
    .chan_o     (chan_o),
    .band_o     (band_o),
    .gain_o     (gain_o),
    .integ_o    (integ_o),
    .adv_o      (adv_o),
    .ack_o      (ack)
  );
endmodule

// File: rtl/knk_cmd_front_chk.sv
module knk_cmd_front_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       miso_o,
  input logic [2:0] pin_s,
  input logic       byte_done,
  input logic [7:0] rx_byte,
  input logic [7:0] ack,
  input logic       adv_o,
  input logic [4:0] presc_o,
  input logic       chan_o,
  input logic [5:0] band_o,
  input logic [5:0] gain_o,
  input logic [4:0] integ_o
);
  p_miso_stable_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_s[0] && $past(pin_s[0]) && !pin_s[1] && !$past(pin_s[1])) |-> $stable(miso_o));

  p_adv_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_o |=> adv_o);

  p_adv_unlock_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(adv_o) |-> ($past(byte_done) && $past(rx_byte) == 8'h71));

  p_settings_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_done |=> $stable({presc_o, chan_o, band_o, gain_o, integ_o}));

  p_ack_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack != 8'h00) |-> adv_o);
endmodule

bind knk_cmd_front knk_cmd_front_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .miso_o   (miso_o),
  .pin_s    (pin_s),
  .byte_done(byte_done),
  .rx_byte  (rx_byte),
  .ack      (ack),
  .adv_o    (adv_o),
  .presc_o  (presc_o),
  .chan_o   (chan_o),
  .band_o   (band_o),
  .gain_o   (gain_o),
  .integ_o  (integ_o)
);

// File: tb/test_knk_cmd_front.sv
module test_knk_cmd_front;
  localparam int HALF = 6;

  typedef struct packed {
    logic [7:0] miso;
    logic [4:0] presc;
    logic [4:0] mhz;
    logic       chan;
    logic [5:0] band;
    logic [5:0] gain;
    logic [4:0] integ;
    logic       adv;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, chan, adv;
  logic [4:0] presc, mhz, integ;
  logic [5:0] band, gain;

  int checks = 0, errors = 0;
  bit ended = 1'b0;

  // reference model state
  logic [4:0] m_presc = '0, m_integ = '0;
  logic [5:0] m_band = '0, m_gain = '0;
  logic       m_chan = 1'b0, m_adv = 1'b0;
  logic [7:0] m_ack = '0;

  item_t exp_q[$], act_q[$];
  string tag_q[$];
  event  got_ev;

  always #10 clk = ~clk;

  knk_cmd_front i_knk_cmd_front (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .presc_o(presc), .clk_mhz_o(mhz), .chan_o(chan),
    .band_o(band), .gain_o(gain), .integ_o(integ), .adv_o(adv)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [4:0] ref_mhz(input logic [3:0] s);
    logic [4:0] r;
    case (s)
      4'd0: r = 5'd4;   4'd1: r = 5'd5;   4'd2: r = 5'd6;
      4'd3: r = 5'd8;   4'd4: r = 5'd10;  4'd5: r = 5'd12;
      4'd6: r = 5'd16;  4'd7: r = 5'd20;  4'd8: r = 5'd24;
      default: r = 5'd0;
    endcase
    return r;
  endfunction

  function automatic item_t model_snap(input logic [7:0] m);
    item_t it;
    it.miso = m; it.presc = m_presc; it.mhz = ref_mhz(m_presc[4:1]);
    it.chan = m_chan; it.band = m_band; it.gain = m_gain;
    it.integ = m_integ; it.adv = m_adv;
    return it;
  endfunction

  function automatic item_t dut_snap(input logic [7:0] m);
    item_t it;
    it.miso = m; it.presc = presc; it.mhz = mhz; it.chan = chan;
    it.band = band; it.gain = gain; it.integ = integ; it.adv = adv;
    return it;
  endfunction

  task automatic model_apply(input logic [7:0] c);
    logic [7:0] a;
    a = 8'h00;
    if (c == 8'h71) begin m_adv = 1'b1; a = 8'h8E; end
    else if (c[7:6] == 2'b00) begin m_band = c[5:0]; a = 8'h01; end
    else if (c[7:6] == 2'b10) begin m_gain = c[5:0]; a = 8'hE0; end
    else if (c[7:5] == 3'b110) begin m_integ = c[4:0]; a = 8'h71; end
    else if (c[7:5] == 3'b010) m_presc = c[4:0];
    else if (c[7:1] == 7'b1110000) m_chan = c[0];
    m_ack = m_adv ? a : 8'h00;
  endtask

  task automatic xfer(input logic [7:0] cmd, input int nbits, output logic [7:0] rx);
    rx = '0;
    @(negedge clk) cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      mosi = cmd[7-i];
      wait_clk(HALF);
      rx[7-i] = miso;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
    cs_n = 1'b1;
    mosi = 1'b0;
    wait_clk(2 * HALF);
  endtask

  // driver: pushes expected item, runs transfer, hands result to monitor
  task automatic send(input logic [7:0] cmd, input string req);
    logic [7:0] rx;
    logic [7:0] exp_m;
    exp_m = m_ack;
    model_apply(cmd);
    exp_q.push_back(model_snap(exp_m));
    tag_q.push_back(req);
    xfer(cmd, 8, rx);
    act_q.push_back(dut_snap(rx));
    -> got_ev;
    wait_clk(2);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(got_ev);
      while (act_q.size() > 0 && exp_q.size() > 0) begin
        item_t a, e;
        string t;
        a = act_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, "miso", int'(a.miso), int'(e.miso));
        chk(t, "settings", int'({a.presc, a.mhz, a.chan, a.band, a.gain, a.integ, a.adv}),
            int'({e.presc, e.mhz, e.chan, e.band, e.gain, e.integ, e.adv}));
      end
    end
  end

  task automatic finish_run;
    if (!ended) begin
      ended = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    logic [7:0] rx;
    wait_clk(3);
    // R1 during reset
    chk("R1", "adv in reset", int'(adv), 0);
    chk("R1", "miso in reset", int'(miso), 0);
    rst_n = 1'b1;
    wait_clk(4);
    chk("R1", "settings after reset", int'({presc, chan, band, gain, integ, adv}), 0);
    chk("R1", "mhz after reset", int'(mhz), 4);
    chk("R11", "miso idle", int'(miso), 0);

    send(8'h2A, "R2 band, R9 miso");
    send(8'h95, "R3 gain");
    send(8'hD3, "R4 integ");
    send(8'h4B, "R5 presc sel5");
    send(8'h51, "R5 presc sel8");
    send(8'h5E, "R5 presc sel15");
    send(8'hE1, "R6 chan1");
    send(8'hE0, "R6 chan0");
    send(8'h7F, "R10 unmatched 7F");
    send(8'hF3, "R10 unmatched F3");
    send(8'hE2, "R10 unmatched E2");
    send(8'h60, "R10 unmatched 60");
    send(8'h71, "R7 unlock, R9 reply zero");
    send(8'h3F, "R7 reply 8E, R11 msb first");
    send(8'hBF, "R8 band ack");
    send(8'hC7, "R8 gain ack");
    send(8'h40, "R8 integ ack");
    send(8'hE1, "R8 presc ack zero");
    send(8'h77, "R8 chan ack zero, R10");
    send(8'h05, "R8 unmatched ack zero");

    // R12: aborted frame after 4 bits, band ack pending
    xfer(8'h9A, 4, rx);
    chk("R12", "settings after abort",
        int'({presc, chan, band, gain, integ, adv}),
        int'({m_presc, m_chan, m_band, m_gain, m_integ, m_adv}));
    send(8'h71, "R12 pending ack kept");
    send(8'h00, "R7 repeat unlock ack");

    wait_clk(10);
    chk("R11", "miso idle at end", int'(miso), 0);
    chk("R12", "scoreboard drained", exp_q.size() + act_q.size(), 0);
    finish_run();
  end
endmodule